// File: doc/BRIEF.md
# Co-processor Channel Command Register Bank

This block is the register bank that sits in front of a four-channel co-processor whose channels each work through memory-resident descriptors. Software reaches it through a simple single-cycle write port and a combinational read port. It holds the global settings and a per-channel interrupt status. It also holds a mask that allows or blocks each channel, a fixed capability word, and a context-buffer pointer. For each channel it holds a command pointer, a pending-work counter, and an error status.

Software queues work by writing a count to a channel's counter. A channel is told to run while its counter is nonzero and its enable bit is set. The channel engine pulses a decrement strobe when it retires a descriptor that asks for it. It pulses a completion strobe, together with an error code, when it finishes. Completion sets the channel's interrupt flag and records the code. A level interrupt is raised while any flag is set and its enable bit is on.

None of the ports carries a data stream, so there is no valid/ready handshake. Every control input is a one-cycle strobe that is always accepted, and no port applies back-pressure.

Top module: `copro_cmd_regs`

## Requirements
- R1: After reset every register reads zero, except the capability word. `irq` and every `chan_start` bit are low.
- R2: Global control at 0x000 stores write bits 23, 22 and 3:0 (bits 3:0 are per-channel interrupt enables). All other bits read zero.
- R3: Global status at 0x010 holds channel n's interrupt flag in bit n. The flag is set by `chan_done[n]`. Writing a mask to 0x018 clears the flags whose mask bit is 1. A completion in the same cycle as a clear leaves the flag set. 0x018 reads zero.
- R4: The channel-enable register at 0x020 stores write bits 7:0, and bit n gates channel n.
- R5: The capability word at 0x040 always reads 0x0005_0001 (bit 0 AES-128, bit 16 SHA-1, bit 18 SHA-256). Writes to it have no effect.
- R6: The context pointer at 0x050 is a full 32-bit read/write register.
- R7: Channel n's command pointer at 0x100 + n·0x40 is a 32-bit read/write register. It also drives `chan_cmd_ptr[32n+31:32n]`.
- R8: A write to channel n's counter at 0x110 + n·0x40 adds write bits 7:0 to the count, saturating at 255. A read returns the count in bits 7:0.
- R9: A `chan_dec[n]` pulse lowers the count by one, applied after any same-cycle add and saturation, but only when the count before the cycle was nonzero. At zero the pulse is ignored.
- R10: `chan_start[n]` is high exactly when channel n's count is nonzero and enable bit n is set.
- R11: Channel n's status at 0x120 + n·0x40 loads `chan_err` byte n on `chan_done[n]`. Writing a mask to 0x128 + n·0x40 clears the masked status bits, and completion wins over a same-cycle clear. The clear alias reads zero.
- R12: `irq` is high while any global status flag n is set together with control bit n.
- R13: Any other address reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wr_addr | input | 12 | Write byte address |
| bus_wr_data | input | 32 | Write data |
| bus_rd_addr | input | 12 | Read byte address |
| bus_rd_data | output | 32 | Read data, combinational from the read address |
| chan_dec | input | 4 | Per-channel count decrement strobe |
| chan_done | input | 4 | Per-channel completion strobe |
| chan_err | input | 32 | Per-channel 8-bit completion code, byte n for channel n |
| chan_start | output | 4 | Per-channel run request |
| chan_cmd_ptr | output | 128 | Per-channel command pointer, word n for channel n |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume the bus and engine strobes stay low while reset is held. They also assume every input changes only between clock edges, so that a rise or fall of `chan_start` or `irq` can be traced to a write or strobe in the cycle before. The bench drives all inputs on the falling edge and keeps them quiet during reset. In its mixed phase it produces overlapping writes, decrements and completions, so that same-cycle set/clear and add/decrement orderings are all exercised within those assumptions.

// File: rtl/copro_cmd_pkg.sv
package copro_cmd_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_GSTAT = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_GCLR  = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_CHEN  = 12'h020;
  localparam logic [ADDR_W-1:0] OFF_CAP   = 12'h040;
  localparam logic [ADDR_W-1:0] OFF_CTX   = 12'h050;

  localparam logic [ADDR_W-1:0] CH_BASE   = 12'h100;
  localparam logic [ADDR_W-1:0] CH_STRIDE = 12'h040;
  localparam logic [ADDR_W-1:0] CH_PTR    = 12'h000;
  localparam logic [ADDR_W-1:0] CH_SEMA   = 12'h010;
  localparam logic [ADDR_W-1:0] CH_STAT   = 12'h020;
  localparam logic [ADDR_W-1:0] CH_SCLR   = 12'h028;

  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h00C0_000F;
  localparam logic [DATA_W-1:0] CAP_WORD  = 32'h0005_0001;
  localparam int CHEN_W = 8;
endpackage

// File: rtl/copro_glob_regs.sv
module copro_glob_regs
  import copro_cmd_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NCH-1:0]    done,
  output logic [DATA_W-1:0] rd_data,
  output logic [NCH-1:0]    irq_en,
  output logic [NCH-1:0]    chan_en,
  output logic [NCH-1:0]    flags
);
  logic [DATA_W-1:0] ctrl_q, ctx_q;
  logic [CHEN_W-1:0] chen_q;
  logic [NCH-1:0]    flag_q, clr_mask;

  assign clr_mask = (wr_en && wr_addr == OFF_GCLR) ? wr_data[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ctx_q  <= '0;
      chen_q <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en && wr_addr == OFF_CTRL) ctrl_q <= wr_data & CTRL_MASK;
      if (wr_en && wr_addr == OFF_CTX)  ctx_q  <= wr_data;
      if (wr_en && wr_addr == OFF_CHEN) chen_q <= wr_data[CHEN_W-1:0];
      // a completion in the same cycle outlasts the clear
      flag_q <= (flag_q & ~clr_mask) | done;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFF_CTRL:  rd_data = ctrl_q;
      OFF_GSTAT: rd_data[NCH-1:0] = flag_q;
      OFF_CHEN:  rd_data[CHEN_W-1:0] = chen_q;
      OFF_CAP:   rd_data = CAP_WORD;
      OFF_CTX:   rd_data = ctx_q;
      default:   rd_data = '0;
    endcase
  end

  assign irq_en  = ctrl_q[NCH-1:0];
  assign chan_en = chen_q[NCH-1:0];
  assign flags   = flag_q;
endmodule

// File: rtl/copro_chan_slot.sv
module copro_chan_slot
  import copro_cmd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE = CH_BASE,
  parameter int CNT_W = 8,
  parameter int ST_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              dec,
  input  logic              done,
  input  logic [ST_W-1:0]   err_code,
  input  logic              enable,
  output logic [DATA_W-1:0] rd_data,
  output logic              start,
  output logic [DATA_W-1:0] cmd_ptr
);
  localparam logic [ADDR_W-1:0] A_PTR  = BASE + CH_PTR;
  localparam logic [ADDR_W-1:0] A_SEMA = BASE + CH_SEMA;
  localparam logic [ADDR_W-1:0] A_STAT = BASE + CH_STAT;
  localparam logic [ADDR_W-1:0] A_SCLR = BASE + CH_SCLR;

  logic [DATA_W-1:0] ptr_q;
  logic [CNT_W-1:0]  cnt_q, cnt_sat, cnt_nx;
  logic [CNT_W:0]    cnt_sum;
  logic [ST_W-1:0]   st_q;
  logic              dec_ok, hit_sema, hit_sclr;

  assign hit_sema = wr_en && wr_addr == A_SEMA;
  assign hit_sclr = wr_en && wr_addr == A_SCLR;

  always_comb begin
    cnt_sum = {1'b0, cnt_q} + (hit_sema ? {1'b0, wr_data[CNT_W-1:0]} : '0);
    cnt_sat = cnt_sum[CNT_W] ? '1 : cnt_sum[CNT_W-1:0];
    dec_ok  = dec && (cnt_q != '0);
    cnt_nx  = cnt_sat - CNT_W'(dec_ok);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
      st_q  <= '0;
    end else begin
      if (wr_en && wr_addr == A_PTR) ptr_q <= wr_data;
      cnt_q <= cnt_nx;
      if (done)          st_q <= err_code;
      else if (hit_sclr) st_q <= st_q & ~wr_data[ST_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_PTR)       rd_data = ptr_q;
    else if (rd_addr == A_SEMA) rd_data[CNT_W-1:0] = cnt_q;
    else if (rd_addr == A_STAT) rd_data[ST_W-1:0] = st_q;
  end

  assign start   = (cnt_q != '0) && enable;
  assign cmd_ptr = ptr_q;
endmodule

// File: rtl/copro_cmd_regs.sv
module copro_cmd_regs
  import copro_cmd_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 8,
  parameter int ST_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr_en,
  input  logic [ADDR_W-1:0]     bus_wr_addr,
  input  logic [DATA_W-1:0]     bus_wr_data,
  input  logic [ADDR_W-1:0]     bus_rd_addr,
  output logic [DATA_W-1:0]     bus_rd_data,
  input  logic [NCH-1:0]        chan_dec,
  input  logic [NCH-1:0]        chan_done,
  input  logic [NCH*ST_W-1:0]   chan_err,
  output logic [NCH-1:0]        chan_start,
  output logic [NCH*DATA_W-1:0] chan_cmd_ptr,
  output logic                  irq
);
  logic [DATA_W-1:0] glob_rd;
  logic [DATA_W-1:0] slot_rd [NCH];
  logic [NCH-1:0]    irq_en, chan_en, flags;

  copro_glob_regs #(.NCH(NCH)) glob_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr_en), .wr_addr(bus_wr_addr), .wr_data(bus_wr_data),
    .rd_addr(bus_rd_addr), .done(chan_done), .rd_data(glob_rd),
    .irq_en(irq_en), .chan_en(chan_en), .flags(flags)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_BASE = CH_BASE + ADDR_W'(g) * CH_STRIDE;
    copro_chan_slot #(.BASE(SLOT_BASE), .CNT_W(CNT_W), .ST_W(ST_W)) slot_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_wr_en), .wr_addr(bus_wr_addr), .wr_data(bus_wr_data),
      .rd_addr(bus_rd_addr),
      .dec(chan_dec[g]), .done(chan_done[g]),
      .err_code(chan_err[g*ST_W +: ST_W]),
      .enable(chan_en[g]),
      .rd_data(slot_rd[g]),
      .start(chan_start[g]),
      .cmd_ptr(chan_cmd_ptr[g*DATA_W +: DATA_W])
    );
  end

  always_comb begin
    bus_rd_data = glob_rd;
    for (int i = 0; i < NCH; i++) bus_rd_data = bus_rd_data | slot_rd[i];
  end

  assign irq = |(flags & irq_en);
endmodule

// File: rtl/copro_cmd_regs_chk.sv
module copro_cmd_regs_chk
  import copro_cmd_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr_en,
  input logic [ADDR_W-1:0]     bus_wr_addr,
  input logic [DATA_W-1:0]     bus_wr_data,
  input logic [ADDR_W-1:0]     bus_rd_addr,
  input logic [DATA_W-1:0]     bus_rd_data,
  input logic [NCH-1:0]        chan_dec,
  input logic [NCH-1:0]        chan_done,
  input logic [NCH-1:0]        chan_start,
  input logic [NCH*DATA_W-1:0] chan_cmd_ptr,
  input logic                  irq
);
  assert_cap_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_addr == OFF_CAP |-> bus_rd_data == CAP_WORD);

  assert_hole_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_addr == 12'h004 |-> bus_rd_data == '0);

  assert_ctx_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(bus_wr_en) && $past(bus_wr_addr) == OFF_CTX && bus_rd_addr == OFF_CTX
    |-> bus_rd_data == $past(bus_wr_data));

  assert_irq_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) && $past(rst_n)
    |-> ($past(|chan_done) || ($past(bus_wr_en) && $past(bus_wr_addr) == OFF_CTRL)));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] B = CH_BASE + ADDR_W'(g) * CH_STRIDE;

    assert_ptr_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(bus_wr_en) && $past(bus_wr_addr) == B + CH_PTR
      |-> chan_cmd_ptr[g*DATA_W +: DATA_W] == $past(bus_wr_data));

    assert_start_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_start[g]) && $past(rst_n)
      |-> $past(bus_wr_en) && ($past(bus_wr_addr) == B + CH_SEMA || $past(bus_wr_addr) == OFF_CHEN));

    assert_start_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chan_start[g]) && $past(rst_n)
      |-> $past(chan_dec[g]) || ($past(bus_wr_en) && $past(bus_wr_addr) == OFF_CHEN));
  end
endmodule

bind copro_cmd_regs copro_cmd_regs_chk #(.NCH(NCH)) chk_i (.*);

// File: tb/copro_cmd_regs_tb.sv
module copro_cmd_regs_tb_top;
  localparam int NCH = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr_en = 1'b0;
  logic [11:0]  bus_wr_addr = '0;
  logic [31:0]  bus_wr_data = '0;
  logic [11:0]  bus_rd_addr = '0;
  logic [31:0]  bus_rd_data;
  logic [3:0]   chan_dec = '0;
  logic [3:0]   chan_done = '0;
  logic [31:0]  chan_err = '0;
  logic [3:0]   chan_start;
  logic [127:0] chan_cmd_ptr;
  logic         irq;

  copro_cmd_regs dut_i (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 1'b0;
  string phase = "R1 reset";

  // behavioural reference state
  logic [31:0] m_ctrl, m_ctx, m_chen, m_flags;
  logic [31:0] m_ptr [4];
  int          m_cnt [4];
  logic [7:0]  m_st [4];

  function automatic logic [31:0] m_read(logic [11:0] a);
    int off, ch;
    case (a)
      12'h000: return m_ctrl;
      12'h010: return m_flags;
      12'h020: return m_chen;
      12'h040: return 32'h0005_0001;
      12'h050: return m_ctx;
      default: ;
    endcase
    if (a >= 12'h100 && a < 12'h200) begin
      ch = (int'(a) - 256) / 64;
      off = (int'(a) - 256) % 64;
      if (off == 0)  return m_ptr[ch];
      if (off == 16) return 32'(m_cnt[ch]);
      if (off == 32) return {24'h0, m_st[ch]};
    end
    return 32'h0;
  endfunction

  function automatic string tag_of(logic [11:0] a);
    int off;
    case (a)
      12'h000: return "R2";
      12'h010, 12'h018: return "R3";
      12'h020: return "R4";
      12'h040: return "R5";
      12'h050: return "R6";
      default: ;
    endcase
    if (a >= 12'h100 && a < 12'h200) begin
      off = (int'(a) - 256) % 64;
      if (off == 0)  return "R7";
      if (off == 16) return "R8 R9";
      if (off == 32 || off == 40) return "R11";
    end
    return "R13";
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s (%s): actual=%0h expected=%0h", tag, phase, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // model update on the edge, comparison shortly after
  always begin
    @(posedge clk);
    cycles++;
    if (!rst_n) begin
      m_ctrl = 0; m_ctx = 0; m_chen = 0; m_flags = 0;
      for (int i = 0; i < 4; i++) begin m_ptr[i] = 0; m_cnt[i] = 0; m_st[i] = 0; end
    end else begin
      logic [3:0] clr;
      clr = (bus_wr_en && bus_wr_addr == 12'h018) ? bus_wr_data[3:0] : 4'h0;
      if (bus_wr_en && bus_wr_addr == 12'h000) m_ctrl = bus_wr_data & 32'h00C0_000F;
      if (bus_wr_en && bus_wr_addr == 12'h020) m_chen = {24'h0, bus_wr_data[7:0]};
      if (bus_wr_en && bus_wr_addr == 12'h050) m_ctx = bus_wr_data;
      m_flags = (m_flags & ~{28'h0, clr}) | {28'h0, chan_done};
      for (int i = 0; i < 4; i++) begin
        int base, s;
        bit dok;
        base = 256 + 64 * i;
        dok = chan_dec[i] && m_cnt[i] != 0;
        s = m_cnt[i];
        if (bus_wr_en && int'(bus_wr_addr) == base + 16) s = s + int'(bus_wr_data[7:0]);
        if (s > 255) s = 255;
        if (dok) s = s - 1;
        m_cnt[i] = s;
        if (bus_wr_en && int'(bus_wr_addr) == base) m_ptr[i] = bus_wr_data;
        if (chan_done[i]) m_st[i] = chan_err[8*i +: 8];
        else if (bus_wr_en && int'(bus_wr_addr) == base + 40) m_st[i] = m_st[i] & ~bus_wr_data[7:0];
      end
    end
    #3;
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
    begin
      logic [3:0] exp_start;
      logic [127:0] exp_ptr;
      for (int i = 0; i < 4; i++) begin
        exp_start[i] = (m_cnt[i] != 0) && m_chen[i];
        exp_ptr[32*i +: 32] = m_ptr[i];
      end
      chk("R10", {124'h0, chan_start}, {124'h0, exp_start});
      chk("R12", {127'h0, irq}, {127'h0, |(m_flags[3:0] & m_ctrl[3:0])});
      chk("R7", chan_cmd_ptr, exp_ptr);
      chk(tag_of(bus_rd_addr), {96'h0, bus_rd_data}, {96'h0, m_read(bus_rd_addr)});
    end
  end

  task automatic cyc(bit we, logic [11:0] wa, logic [31:0] wd, logic [11:0] ra,
                     logic [3:0] dec = 0, logic [3:0] dn = 0, logic [31:0] er = 0);
    @(negedge clk);
    bus_wr_en = we; bus_wr_addr = wa; bus_wr_data = wd; bus_rd_addr = ra;
    chan_dec = dec; chan_done = dn; chan_err = er;
  endtask

  function automatic logic [11:0] pick_addr(int r);
    logic [11:0] list [17] = '{12'h000, 12'h010, 12'h018, 12'h020, 12'h040, 12'h050, 12'h004,
                              12'h100, 12'h110, 12'h120, 12'h128, 12'h150, 12'h190,
                              12'h1A8, 12'h1D0, 12'h1E0, 12'h1E8};
    return list[r % 17];
  endfunction

  initial begin
    logic [11:0] sweep [10] = '{12'h000, 12'h010, 12'h020, 12'h040, 12'h050,
                               12'h100, 12'h110, 12'h120, 12'h1D0, 12'h1E0};
    void'($urandom(7));
    repeat (3) cyc(0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset values visible through every register
    foreach (sweep[k]) cyc(0, 0, 0, sweep[k]);

    phase = "R2 control mask";
    cyc(1, 12'h000, 32'hFFFF_FFFF, 12'h000);
    cyc(0, 0, 0, 12'h000);
    phase = "R5 capability write ignored";
    cyc(1, 12'h040, 32'h0, 12'h040);
    cyc(0, 0, 0, 12'h040);
    phase = "R13 unmapped write ignored";
    cyc(1, 12'h004, 32'hDEAD_BEEF, 12'h004);
    cyc(1, 12'h118, 32'h55, 12'h118);
    cyc(0, 0, 0, 12'h004);
    phase = "R6 context pointer";
    cyc(1, 12'h050, 32'hFFFF_0000, 12'h050);
    cyc(0, 0, 0, 12'h050);
    phase = "R7 command pointers";
    for (int i = 0; i < 4; i++) cyc(1, 12'(256 + 64 * i), 32'h1000_0000 + 32'(i * 16), 12'(256 + 64 * i));
    phase = "R8 saturation";
    cyc(1, 12'h110, 32'hFFFF_FFC8, 12'h110);
    cyc(1, 12'h110, 32'h64, 12'h110);
    cyc(0, 0, 0, 12'h110);
    phase = "R10 start gated by enable";
    cyc(1, 12'h020, 32'h0000_0001, 12'h020);
    cyc(0, 0, 0, 12'h020);
    phase = "R9 decrement at zero and at saturation";
    cyc(0, 0, 0, 12'h150, 4'b0010);
    cyc(1, 12'h110, 32'h5, 12'h110, 4'b0001);
    cyc(0, 0, 0, 12'h110, 4'b0001);
    cyc(1, 12'h150, 32'h0, 12'h150, 4'b0010);
    phase = "R11 completion and status clear";
    cyc(0, 0, 0, 12'h120, 4'b0001, 4'b0001, 32'h0000_00A5);
    cyc(1, 12'h128, 32'h0000_0005, 12'h120);
    cyc(1, 12'h128, 32'hFFFF_FFFF, 12'h120, 0, 4'b0001, 32'h0000_003C);
    cyc(1, 12'h128, 32'hFFFF_FFFF, 12'h120);
    phase = "R3 R12 flags and interrupt";
    cyc(0, 0, 0, 12'h010, 0, 4'b1010, 32'h0102_0304);
    cyc(1, 12'h018, 32'h0000_0002, 12'h010);
    cyc(1, 12'h000, 32'h0, 12'h010);
    cyc(1, 12'h018, 32'hF, 12'h010, 0, 4'b1000, 0);
    cyc(1, 12'h018, 32'hF, 12'h010);

    phase = "mixed traffic R3 R8 R9 R10 R11 R12";
    for (int n = 0; n < 2500; n++) begin
      int r;
      logic [31:0] d;
      logic [11:0] wa;
      r = int'($urandom % 1000);
      d = $urandom;
      wa = pick_addr(int'($urandom % 17));
      if (wa[5:0] == 6'h10 || wa == 12'h020) d = d & 32'h0000_01FF;
      cyc(r < 400, wa, d, pick_addr(int'($urandom % 17)),
          4'($urandom) & 4'($urandom), 4'($urandom) & 4'($urandom) & 4'($urandom), $urandom);
    end
    cyc(0, 0, 0, 0);
    @(negedge clk);
    finish_run();
  end
endmodule